// File: doc/BRIEF.md
# Shared-Offset Interrupt Enable and Event Status Register

This block is one 8-bit register on a simple register bus. Writes and reads at its single offset reach two separate stores. A write loads a set of enable bits. A read returns a byte of latched event flags and clears those flags in the same access. The enable settings can never be read back.

Five event inputs feed the flags:

- a power-button level
- an RTC wake-up pulse
- an alternate-button level
- a supply under-voltage flag
- a supply over-voltage flag

The inputs are treated as synchronous to the register clock. The block raises an interrupt output when a pending flag has its enable set. It raises a shutdown request when an under-voltage flag is pending and the shutdown enable is set.

Bit 1 has a split meaning. On write it is the shutdown enable. On read it is the under-voltage flag. Enable bit 0 governs the interrupt for both supply flags. Only the power-on reset input clears either store. Software reads the byte, acts on each set flag, and relies on the read to re-arm the flags.

Top module: `irq_shared_reg`

## Requirements
- R1: After power-on reset (por_n low), the enable and status stores are 0x00. irq_o and shutdown_req_o are low and bus_rdata is 0x00. A flag that is captured before any enable has been written leaves irq_o low.
- R2: A write strobe with bus_addr equal to 0x24 loads the enables from bus_wdata. Bit 7 is the power-button enable, bit 6 the wake-up enable, bit 5 the alternate-button enable, bit 1 the shutdown enable and bit 0 the supply-supervision interrupt enable. A write to any other address leaves the enables unchanged.
- R3: A read strobe with bus_addr equal to 0x24 places the status byte on bus_rdata in the cycle after the strobe. Bit 7 is the power-button flag, bit 6 the wake-up flag, bit 5 the alternate-button flag, bit 1 the under-voltage flag and bit 0 the over-voltage flag. bus_rdata bits 4 to 2 are always 0, and the enable values never appear on bus_rdata.
- R4: A read at 0x24 clears every status bit. A read that follows with no new event returns 0x00.
- R5: An event input that is high in the same cycle as a clearing read leaves its flag set after that read. That flag is not part of the byte that read returns.
- R6: A flag is set by its input being high at a clock edge, whatever the enables hold. It stays set after the input falls, until a read at 0x24.
- R7: irq_o is high exactly when one of these holds: the power-button flag and its enable are set; the wake-up flag and its enable are set; the alternate-button flag and its enable are set; or the under-voltage or over-voltage flag is set while enable bit 0 is set.
- R8: shutdown_req_o is high exactly when the under-voltage flag is set and enable bit 1 is set.
- R9: A read strobe at any address other than 0x24 returns 0x00 on bus_rdata and leaves the status flags unchanged.
- R10: bus_wdata bits 4 to 2 have no effect. Writing 0x1C leaves irq_o and shutdown_req_o low while every flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd, 0 otherwise |
| ev_pwr_btn | input | 1 | Power-button high level |
| ev_rtc_wake | input | 1 | RTC wake-up event |
| ev_alt_btn | input | 1 | Alternate-button high level |
| ev_uv | input | 1 | Supply under-voltage flag |
| ev_ov | input | 1 | Supply over-voltage flag |
| irq_o | output | 1 | Interrupt request |
| shutdown_req_o | output | 1 | Shutdown request |

## Verification
The interrupt function is first driven with each event source on its own under matching enables, then under an all-zero enable set. Comparing the two runs separates the role of the status latch from the role of the enable gate. The two supply flags are then driven one at a time under enable bit 0 alone and under enable bit 1 alone. These runs show that bit 0 gates both supply flags, while bit 1 drives only the shutdown request and only from the under-voltage flag.

An event is also raised in the same cycle as a clearing read. This case tells a set-priority latch apart from one that lets the clear win. Reads and writes at a wrong address, and writes that set only the unused bits, show that neither store changes in those cases.

// File: rtl/irqsr_pkg.sv
package irqsr_pkg;

   typedef struct packed {
      logic pwr;
      logic wake;
      logic alt;
      logic uv;
      logic ov;
   } irqsr_events_t;

   function automatic int unsigned irqsr_bit(input int unsigned pos, input int unsigned w);
      return (pos < w) ? (32'd1 << pos) : 32'd0;
   endfunction

endpackage

// File: rtl/irqsr_status_latch.sv
module irqsr_status_latch #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] q_next;

   // Set wins over clear so that an event landing on a read survives it.
   always_comb begin
      if (clr_i) q_next = set_i & MASK;
      else       q_next = (q_o | set_i) & MASK;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) q_o <= '0;
      else        q_o <= q_next;
   end

endmodule

// File: rtl/irqsr_enable_store.sv
module irqsr_enable_store #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    q_o <= '0;
      else if (we_i) q_o <= wdata_i & MASK;
   end

endmodule

// File: rtl/irqsr_irq_gen.sv
module irqsr_irq_gen #(
   parameter int unsigned W        = 8,
   parameter int unsigned PWR_POS  = 7,
   parameter int unsigned WAKE_POS = 6,
   parameter int unsigned ALT_POS  = 5,
   parameter int unsigned UV_POS   = 1,
   parameter int unsigned OV_POS   = 0
) (
   input  logic [W-1:0] status_i,
   input  logic [W-1:0] enable_i,
   output logic         irq_o,
   output logic         shutdown_o
);

   logic src_pwr, src_wake, src_alt, src_supply;

   always_comb begin
      src_pwr    = status_i[PWR_POS]  & enable_i[PWR_POS];
      src_wake   = status_i[WAKE_POS] & enable_i[WAKE_POS];
      src_alt    = status_i[ALT_POS]  & enable_i[ALT_POS];
      // One enable governs both supply flags.
      src_supply = (status_i[UV_POS] | status_i[OV_POS]) & enable_i[OV_POS];
      irq_o      = src_pwr | src_wake | src_alt | src_supply;
      shutdown_o = status_i[UV_POS] & enable_i[UV_POS];
   end

endmodule

// File: rtl/irq_shared_reg.sv
module irq_shared_reg
   import irqsr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 'h24,
   parameter int unsigned PWR_POS   = 7,
   parameter int unsigned WAKE_POS  = 6,
   parameter int unsigned ALT_POS   = 5,
   parameter int unsigned UV_POS    = 1,
   parameter int unsigned OV_POS    = 0,
   parameter bit          RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_pwr_btn,
   input  logic              ev_rtc_wake,
   input  logic              ev_alt_btn,
   input  logic              ev_uv,
   input  logic              ev_ov,
   output logic              irq_o,
   output logic              shutdown_req_o
);

   localparam int unsigned NUM_SRC = 5;
   localparam logic [DATA_W-1:0] USED_MASK = DATA_W'(
      irqsr_bit(PWR_POS, DATA_W) | irqsr_bit(WAKE_POS, DATA_W) |
      irqsr_bit(ALT_POS, DATA_W) | irqsr_bit(UV_POS, DATA_W) |
      irqsr_bit(OV_POS, DATA_W));

   // Elaboration-time parameter checks
   if (DATA_W < NUM_SRC) begin : g_bad_width
      $error("irq_shared_reg: DATA_W too small for the sources");
   end
   if ($countones(USED_MASK) != NUM_SRC) begin : g_bad_pos
      $error("irq_shared_reg: bit positions overlap or exceed DATA_W");
   end

   irqsr_events_t     ev;
   logic [DATA_W-1:0] ev_set;
   logic              hit, wr_hit, rd_hit;
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] enable_q;

   assign ev  = '{pwr: ev_pwr_btn, wake: ev_rtc_wake, alt: ev_alt_btn,
                  uv: ev_uv, ov: ev_ov};
   assign hit = (bus_addr == REG_OFFSET);
   assign wr_hit = bus_wr & hit;
   assign rd_hit = bus_rd & hit;

   always_comb begin
      ev_set           = '0;
      ev_set[PWR_POS]  = ev.pwr;
      ev_set[WAKE_POS] = ev.wake;
      ev_set[ALT_POS]  = ev.alt;
      ev_set[UV_POS]   = ev.uv;
      ev_set[OV_POS]   = ev.ov;
   end

   irqsr_status_latch #(.W(DATA_W), .MASK(USED_MASK)) u_status (
      .clk(clk), .por_n(por_n), .set_i(ev_set), .clr_i(rd_hit), .q_o(status_q)
   );

   irqsr_enable_store #(.W(DATA_W), .MASK(USED_MASK)) u_enable (
      .clk(clk), .por_n(por_n), .we_i(wr_hit), .wdata_i(bus_wdata), .q_o(enable_q)
   );

   irqsr_irq_gen #(
      .W(DATA_W), .PWR_POS(PWR_POS), .WAKE_POS(WAKE_POS), .ALT_POS(ALT_POS),
      .UV_POS(UV_POS), .OV_POS(OV_POS)
   ) u_irq (
      .status_i(status_q), .enable_i(enable_q),
      .irq_o(irq_o), .shutdown_o(shutdown_req_o)
   );

   // Readback path: registered (data the cycle after the strobe) or same-cycle.
   if (RDATA_REG) begin : g_rdata_reg
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)      bus_rdata <= '0;
         else if (rd_hit) bus_rdata <= status_q;
         else             bus_rdata <= '0;
      end
   end else begin : g_rdata_comb
      assign bus_rdata = rd_hit ? status_q : '0;
   end

endmodule

// File: rtl/irqsr_checker.sv
module irqsr_checker #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 'h24,
   parameter logic [DATA_W-1:0] USED_MASK = 8'hE3,
   parameter int unsigned UV_POS = 1
) (
   input logic              clk,
   input logic              por_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] ev_set,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] enable_q,
   input logic              irq_o,
   input logic              shutdown_req_o
);

   logic rd_hit;
   assign rd_hit = bus_rd && (bus_addr == REG_OFFSET);

   a_r2_other_addr_write: assert property (@(posedge clk) disable iff (!por_n)
      (bus_wr && bus_addr != REG_OFFSET) |=> $stable(enable_q));

   a_r3_unused_read_zero: assert property (@(posedge clk) disable iff (!por_n)
      (bus_rdata & ~USED_MASK) == '0);

   a_r4_clear_on_read: assert property (@(posedge clk) disable iff (!por_n)
      (rd_hit && ev_set == '0) |=> status_q == '0);

   a_r5_no_lost_event: assert property (@(posedge clk) disable iff (!por_n)
      (|ev_set) |=> ((status_q & $past(ev_set)) == $past(ev_set)));

   a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!por_n)
      !rd_hit |=> ((status_q & $past(status_q)) == $past(status_q)));

   a_r7_no_enable_no_irq: assert property (@(posedge clk) disable iff (!por_n)
      (enable_q == '0) |-> !irq_o);

   a_r8_shutdown_needs_enable: assert property (@(posedge clk) disable iff (!por_n)
      shutdown_req_o |-> enable_q[UV_POS]);

   a_r9_other_addr_read: assert property (@(posedge clk) disable iff (!por_n)
      (bus_rd && bus_addr != REG_OFFSET) |=> bus_rdata == '0);

endmodule

bind irq_shared_reg irqsr_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET),
   .USED_MASK(USED_MASK), .UV_POS(UV_POS)
) u_chk (
   .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ev_set(ev_set),
   .status_q(status_q), .enable_q(enable_q), .irq_o(irq_o),
   .shutdown_req_o(shutdown_req_o)
);

// File: tb/irq_shared_reg_tb.sv
module irq_shared_reg_tb;

   localparam logic [7:0] OFS = 8'h24;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       ev_pwr_btn = 0, ev_rtc_wake = 0, ev_alt_btn = 0, ev_uv = 0, ev_ov = 0;
   logic       irq_o, shutdown_req_o;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_shared_reg u_dut (
      .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .ev_pwr_btn(ev_pwr_btn), .ev_rtc_wake(ev_rtc_wake), .ev_alt_btn(ev_alt_btn),
      .ev_uv(ev_uv), .ev_ov(ev_ov), .irq_o(irq_o), .shutdown_req_o(shutdown_req_o)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // Each bus action starts on a falling edge and ends on the next falling edge.
   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   // events: {pwr, wake, alt, uv, ov}
   task automatic pulse_events(input logic [4:0] e);
      {ev_pwr_btn, ev_rtc_wake, ev_alt_btn, ev_uv, ev_ov} = e;
      @(negedge clk);
      {ev_pwr_btn, ev_rtc_wake, ev_alt_btn, ev_uv, ev_ov} = '0;
   endtask

   task automatic drain();
      logic [7:0] d;
      bus_read(OFS, d);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 rdata after reset", bus_rdata, 8'h00);
      check("R1 irq after reset", {7'd0, irq_o}, 8'h00);
      check("R1 shutdown after reset", {7'd0, shutdown_req_o}, 8'h00);
      pulse_events(5'b10000);
      check("R1 irq with no enables", {7'd0, irq_o}, 8'h00);
      bus_read(OFS, d);
      check("R6 flag set without enable", d, 8'h80);
      bus_read(OFS, d);
      check("R4 second read empty", d, 8'h00);
   endtask

   task automatic t_each_source();
      logic [7:0] d;
      bus_write(OFS, 8'hE0);
      pulse_events(5'b01000);
      check("R7 wake irq", {7'd0, irq_o}, 8'h01);
      bus_read(OFS, d);
      check("R3 wake flag bit 6", d, 8'h40);
      check("R4 irq drops after read", {7'd0, irq_o}, 8'h00);
      pulse_events(5'b00100);
      @(negedge clk);
      check("R6 alt flag sticky, irq", {7'd0, irq_o}, 8'h01);
      bus_read(OFS, d);
      check("R3 alt flag bit 5", d, 8'h20);
      pulse_events(5'b11111);
      bus_read(OFS, d);
      check("R3 all flags, unused bits zero", d, 8'hE3);
      bus_write(OFS, 8'h40);
      pulse_events(5'b10100);
      check("R7 pwr/alt not enabled", {7'd0, irq_o}, 8'h00);
      drain();
   endtask

   task automatic t_supply();
      logic [7:0] d;
      bus_write(OFS, 8'h01);
      pulse_events(5'b00001);
      check("R7 ov under enable 0", {7'd0, irq_o}, 8'h01);
      check("R8 no shutdown with bit1 off", {7'd0, shutdown_req_o}, 8'h00);
      drain();
      pulse_events(5'b00010);
      check("R7 uv under enable 0", {7'd0, irq_o}, 8'h01);
      drain();
      bus_write(OFS, 8'h02);
      pulse_events(5'b00010);
      check("R8 shutdown on uv", {7'd0, shutdown_req_o}, 8'h01);
      check("R7 no irq with only bit1", {7'd0, irq_o}, 8'h00);
      bus_read(OFS, d);
      check("R3 uv flag bit 1", d, 8'h02);
      check("R8 shutdown clears on read", {7'd0, shutdown_req_o}, 8'h00);
      pulse_events(5'b00001);
      check("R8 ov gives no shutdown", {7'd0, shutdown_req_o}, 8'h00);
      drain();
   endtask

   task automatic t_same_cycle();
      logic [7:0] d;
      pulse_events(5'b10000);
      ev_rtc_wake = 1'b1;
      bus_read(OFS, d);
      ev_rtc_wake = 1'b0;
      check("R5 read excludes same-cycle event", d, 8'h80);
      bus_read(OFS, d);
      check("R5 same-cycle event kept", d, 8'h40);
   endtask

   task automatic t_wrong_addr();
      logic [7:0] d;
      bus_write(OFS, 8'h80);
      bus_write(8'h25, 8'h00);
      pulse_events(5'b10000);
      check("R2 other-address write ignored", {7'd0, irq_o}, 8'h01);
      bus_read(8'h23, d);
      check("R9 other-address read zero", d, 8'h00);
      check("R9 status kept, irq", {7'd0, irq_o}, 8'h01);
      bus_read(OFS, d);
      check("R9 flag still there", d, 8'h80);
      check("R3 enables not returned", d & 8'h7F, 8'h00);
   endtask

   task automatic t_unused_bits();
      bus_write(OFS, 8'h1C);
      pulse_events(5'b11111);
      check("R10 unused enable bits, irq", {7'd0, irq_o}, 8'h00);
      check("R10 unused enable bits, shutdown", {7'd0, shutdown_req_o}, 8'h00);
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_each_source();
      t_supply();
      t_same_cycle();
      t_wrong_addr();
      t_unused_bits();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule